// File: doc/BRIEF.md
# Serial Diagnostic Command Slave

This block is the serial command port of a multi-channel load-driver controller. A host writes one 8-bit byte per chip-select window, most significant bit first. The block decodes the byte when chip select is released. It drives command and programming strobes towards the driver logic, and it latches diagnostic results that the driver logic reports. During the following transfer it shifts the response to that byte back to the host, so every answer arrives one frame late.

All pins are oversampled by the system clock through a short synchronizer chain. The clock level seen when chip select falls picks one of two framing variants: idle-low clock or idle-high clock. In both variants data is taken on rising clock edges and the output moves on falling edges. Frames of any length other than eight bits are discarded. A programming write needs two back-to-back bytes: an arm byte followed by the data byte. The data byte is withheld while any driver is active.

Top module: `spi_diag_slave`

## Requirements
- R1: A chip-select window with exactly 8 rising clock edges is a valid frame. The bits are assembled MSB first. If no programming write is pending, one `cmdStrobe` pulse follows chip-select rise, with `cmdCode` equal to the byte.
- R2: A window with any other count of rising edges (7, 9, ...) produces no strobe. It leaves the response that the next frame returns unchanged.
- R3: Each frame shifts out the response to the last valid frame, MSB first. For byte 0x00 (no-op), for the arm byte 0xA5, for a programming data byte and for any byte without a defined meaning, the response is the received byte itself. After reset the response is 0x00.
- R4: Byte 0x96 is an echo test. The next frame returns 0x69.
- R5: Byte 0xC8 is an identity query. The next frame returns `strapTwoCh` in bit 7, with bits 6..0 at zero.
- R6: Bytes 0xC1, 0xC2 and 0xD0 to 0xD3 start a diagnostic mode. `diagActive` goes high and the response starts at 0x00. While the mode is active, each `diagValid` pulse ORs `diagResult` into the response. While no mode is active, `diagValid` has no effect.
- R7: The next valid frame ends the active mode and replaces the latched result, so results are read once. `diagActive` stays high only when that frame is itself a diagnostic byte.
- R8: `altMode` takes the `sclk` level at the chip-select fall. In the idle-high variant, the falling edge that comes before the first rising edge does not advance the output.
- R9: `misoOe` is low and `miso` is high impedance while chip select is high. The first response bit is on `miso` before the first rising clock edge.
- R10: After a valid 0xA5 frame, the next valid frame is a data byte. It gives one `progStrobe` pulse with `progData` equal to the byte, and no `cmdStrobe`. If `driverActive` is high at its chip-select rise, no strobe is given. A discarded frame between the two bytes cancels the arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, high impedance when deselected |
| misoOe | output | 1 | Drive enable of `miso` |
| altMode | output | 1 | 1 when the current or last window started with the clock high |
| strapTwoCh | input | 1 | Variant strap reported in bit 7 of the identity response |
| driverActive | input | 1 | High while any driver output is on |
| diagValid | input | 1 | One-cycle pulse that presents a diagnostic result |
| diagResult | input | 8 | Diagnostic result bits |
| cmdStrobe | output | 1 | One-cycle pulse per decoded command |
| cmdCode | output | 8 | Last decoded command byte |
| progStrobe | output | 1 | One-cycle pulse per accepted programming byte |
| progData | output | 8 | Last accepted programming byte |
| diagActive | output | 1 | A diagnostic mode is active |

## Verification
The bench builds the block with the default two synchronizer stages. With these, a pin change reaches the edge detectors three system clocks later, so a serial half period of eight system clocks exercises the full edge path while keeping every frame short. At that depth the bench can run a long random stream of frames in both clock variants, at lengths 7, 8 and 9 bits. It mixes in armed programming pairs, driver activity and diagnostic result pulses, and predicts each returned byte from the previous valid frame.

// File: rtl/spi_diag_pkg.sv
`timescale 1ns/1ps
package spi_diag_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_NOP    = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_ECHO   = 8'h96;
  localparam logic [BYTE_W-1:0] ECHO_REPLY = 8'h69;
  localparam logic [BYTE_W-1:0] CMD_IDENT  = 8'hC8;
  localparam logic [BYTE_W-1:0] CMD_ARM    = 8'hA5;
  localparam logic [BYTE_W-1:0] CMD_SHORT  = 8'hC1;
  localparam logic [BYTE_W-1:0] CMD_CONT   = 8'hC2;
  localparam logic [5:0]        CMD_MEAS_HI = 6'b110100;

  // datapath -> control: frame completion events
  typedef struct packed {
    logic              frameEnd;
    logic              frameOk;
    logic [BYTE_W-1:0] rxByte;
  } frameEvt_t;

  // control -> datapath: byte to present in the next window
  typedef struct packed {
    logic [BYTE_W-1:0] respByte;
  } ctrlToDp_t;

  function automatic logic isDiagCmd(input logic [BYTE_W-1:0] b);
    return (b == CMD_SHORT) || (b == CMD_CONT) || (b[7:2] == CMD_MEAS_HI);
  endfunction
endpackage

// File: rtl/spi_diag_dp.sv
`timescale 1ns/1ps
module spi_diag_dp
  import spi_diag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclk,
  input  logic      csN,
  input  logic      mosi,
  input  ctrlToDp_t ctl,
  output frameEvt_t evt,
  output logic      misoOut,
  output logic      misoOe,
  output logic      altMode
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL  = '1;
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(BYTE_W);

  logic sclkQ, csQ, mosiQ;

  generate
    if (SYNC_STAGES <= 1) begin : gSync1
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclkQ <= 1'b0;
          csQ   <= 1'b1;
          mosiQ <= 1'b0;
        end else begin
          sclkQ <= sclk;
          csQ   <= csN;
          mosiQ <= mosi;
        end
      end
    end else begin : gSyncN
      logic [SYNC_STAGES-1:0] sclkS, csS, mosiS;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclkS <= '0;
          csS   <= '1;
          mosiS <= '0;
        end else begin
          sclkS <= {sclkS[SYNC_STAGES-2:0], sclk};
          csS   <= {csS[SYNC_STAGES-2:0], csN};
          mosiS <= {mosiS[SYNC_STAGES-2:0], mosi};
        end
      end
      assign sclkQ = sclkS[SYNC_STAGES-1];
      assign csQ   = csS[SYNC_STAGES-1];
      assign mosiQ = mosiS[SYNC_STAGES-1];
    end
  endgenerate

  logic sclkP, csP;
  logic csFall, csRise, sclkRise, sclkFall;
  logic [CNT_W-1:0]  bitCnt;
  logic              seenRise;
  logic [BYTE_W-1:0] shiftIn, shiftOut;

  always_comb begin
    csFall   = csP && !csQ;
    csRise   = !csP && csQ;
    sclkRise = !sclkP && sclkQ && !csQ;
    sclkFall = sclkP && !sclkQ && !csQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkP    <= 1'b0;
      csP      <= 1'b1;
      bitCnt   <= '0;
      seenRise <= 1'b0;
      shiftIn  <= '0;
      shiftOut <= '0;
      altMode  <= 1'b0;
    end else begin
      sclkP <= sclkQ;
      csP   <= csQ;
      if (csFall) begin
        altMode  <= sclkQ;
        bitCnt   <= '0;
        seenRise <= 1'b0;
        shiftOut <= ctl.respByte;
      end else if (sclkRise) begin
        shiftIn  <= {shiftIn[BYTE_W-2:0], mosiQ};
        seenRise <= 1'b1;
        if (bitCnt != CNT_FULL) bitCnt <= bitCnt + 1'b1;
      end else if (sclkFall && (!altMode || seenRise)) begin
        shiftOut <= {shiftOut[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_comb begin
    evt.frameEnd = csRise;
    evt.frameOk  = (bitCnt == CNT_FRAME);
    evt.rxByte   = shiftIn;
    misoOe       = !csQ;
    misoOut      = shiftOut[BYTE_W-1];
  end

  assert_full_frame_has_edges_R1: assert property (@(posedge clk) disable iff (!rstN)
    (evt.frameEnd && evt.frameOk) |-> seenRise);

  assert_idle_output_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (csQ && csP) |=> $stable(shiftOut));

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !csFall |=> $stable(altMode));
endmodule

// File: rtl/spi_diag_ctrl.sv
`timescale 1ns/1ps
module spi_diag_ctrl
  import spi_diag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  frameEvt_t         evt,
  input  logic              strapTwoCh,
  input  logic              driverActive,
  input  logic              diagValid,
  input  logic [BYTE_W-1:0] diagResult,
  output ctrlToDp_t         ctl,
  output logic              cmdStrobe,
  output logic [BYTE_W-1:0] cmdCode,
  output logic              progStrobe,
  output logic [BYTE_W-1:0] progData,
  output logic              diagActive
);
  logic              armed;
  logic [BYTE_W-1:0] resp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed      <= 1'b0;
      resp       <= '0;
      cmdStrobe  <= 1'b0;
      cmdCode    <= '0;
      progStrobe <= 1'b0;
      progData   <= '0;
      diagActive <= 1'b0;
    end else begin
      cmdStrobe  <= 1'b0;
      progStrobe <= 1'b0;
      if (evt.frameEnd) begin
        if (!evt.frameOk) begin
          armed <= 1'b0;
        end else if (armed) begin
          armed      <= 1'b0;
          diagActive <= 1'b0;
          resp       <= evt.rxByte;
          if (!driverActive) begin
            progStrobe <= 1'b1;
            progData   <= evt.rxByte;
          end
        end else begin
          cmdStrobe  <= 1'b1;
          cmdCode    <= evt.rxByte;
          diagActive <= 1'b0;
          resp       <= evt.rxByte;
          if (evt.rxByte == CMD_ECHO) begin
            resp <= ECHO_REPLY;
          end else if (evt.rxByte == CMD_IDENT) begin
            resp <= {strapTwoCh, {(BYTE_W-1){1'b0}}};
          end else if (evt.rxByte == CMD_ARM) begin
            armed <= 1'b1;
          end else if (isDiagCmd(evt.rxByte)) begin
            diagActive <= 1'b1;
            resp       <= '0;
          end
        end
      end else if (diagActive && diagValid) begin
        resp <= resp | diagResult;
      end
    end
  end

  assign ctl.respByte = resp;

  assert_strobe_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdStrobe, progStrobe}));

  assert_cmd_only_full_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> $past(evt.frameOk));

  assert_resp_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!evt.frameEnd && !(diagActive && diagValid)) |=> $stable(resp));

  assert_prog_needs_arm_R10: assert property (@(posedge clk) disable iff (!rstN)
    progStrobe |-> ($past(armed) && !$past(driverActive)));

  assert_data_not_command_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> !$past(armed));
endmodule

// File: rtl/spi_diag_slave.sv
`timescale 1ns/1ps
module spi_diag_slave
  import spi_diag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       mosi,
  output logic       miso,
  output logic       misoOe,
  output logic       altMode,
  input  logic       strapTwoCh,
  input  logic       driverActive,
  input  logic       diagValid,
  input  logic [7:0] diagResult,
  output logic       cmdStrobe,
  output logic [7:0] cmdCode,
  output logic       progStrobe,
  output logic [7:0] progData,
  output logic       diagActive
);
  frameEvt_t evt;
  ctrlToDp_t ctl;
  logic      misoOut;

  spi_diag_dp #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .ctl(ctl), .evt(evt), .misoOut(misoOut), .misoOe(misoOe), .altMode(altMode)
  );

  spi_diag_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .evt(evt), .strapTwoCh(strapTwoCh),
    .driverActive(driverActive), .diagValid(diagValid), .diagResult(diagResult),
    .ctl(ctl), .cmdStrobe(cmdStrobe), .cmdCode(cmdCode),
    .progStrobe(progStrobe), .progData(progData), .diagActive(diagActive)
  );

  assign miso = misoOe ? misoOut : 1'bz;
endmodule

// File: tb/tb_spi_diag_slave.sv
`timescale 1ns/1ps
module tb_spi_diag_slave;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, misoOe, altMode;
  logic strapTwoCh = 1'b0, driverActive = 1'b0, diagValid = 1'b0;
  logic [7:0] diagResult = 8'h00;
  logic cmdStrobe, progStrobe, diagActive;
  logic [7:0] cmdCode, progData;

  int checks = 0, fails = 0;
  int cmdCnt = 0, progCnt = 0;
  logic [7:0] lastCode = 8'h00, lastProg = 8'h00;

  logic [7:0] expResp = 8'h00;
  bit expArmed = 1'b0, expDiag = 1'b0;
  string respTag = "R3";

  always #2.5 clk = ~clk;

  spi_diag_slave dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .misoOe(misoOe), .altMode(altMode), .strapTwoCh(strapTwoCh),
    .driverActive(driverActive), .diagValid(diagValid), .diagResult(diagResult),
    .cmdStrobe(cmdStrobe), .cmdCode(cmdCode), .progStrobe(progStrobe),
    .progData(progData), .diagActive(diagActive)
  );

  always @(negedge clk) begin
    if (cmdStrobe) begin cmdCnt <= cmdCnt + 1; lastCode <= cmdCode; end
    if (progStrobe) begin progCnt <= progCnt + 1; lastProg <= progData; end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit isDiag(input logic [7:0] b);
    return (b == 8'hC1) || (b == 8'hC2) || (b[7:2] == 6'b110100);
  endfunction

  task automatic xfer(input logic [7:0] b, input int n, input bit alt, output logic [15:0] rx);
    logic [15:0] snd;
    snd = {b, 8'h00};
    rx = '0;
    sclk = alt; mosi = 1'b0;
    waitClk(HP);
    csN = 1'b0;
    waitClk(HP);
    chk(misoOe == 1'b1, "R9 enable", {15'd0, misoOe}, 16'd1);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      mosi = snd[15-i];
      waitClk(HP);
      rx = {rx[14:0], miso};
      sclk = 1'b1;
      waitClk(HP);
    end
    if (!alt) begin sclk = 1'b0; waitClk(HP); end
    csN = 1'b1;
    waitClk(HP);
  endtask

  task automatic doFrame(input logic [7:0] b, input int n, input bit alt);
    logic [15:0] rx, expRx;
    int c0, p0;
    bit valid, wasArmed, expProg;
    string rtag;
    c0 = cmdCnt; p0 = progCnt;
    expRx = {expResp, 8'h00} >> (16 - n);
    rtag = respTag;
    xfer(b, n, alt, rx);
    chk(rx == expRx, rtag, rx, expRx);
    valid = (n == 8);
    wasArmed = expArmed;
    expProg = 1'b0;
    if (!valid) begin
      expArmed = 1'b0;
    end else if (expArmed) begin
      expArmed = 1'b0; expDiag = 1'b0; expResp = b; respTag = "R3";
      expProg = !driverActive;
    end else begin
      expDiag = 1'b0; expResp = b; respTag = "R3";
      if (b == 8'h96) begin expResp = 8'h69; respTag = "R4"; end
      else if (b == 8'hC8) begin expResp = {strapTwoCh, 7'd0}; respTag = "R5"; end
      else if (b == 8'hA5) expArmed = 1'b1;
      else if (isDiag(b)) begin expDiag = 1'b1; expResp = 8'h00; respTag = "R6"; end
    end
    if (valid && !wasArmed) begin
      chk(cmdCnt == c0 + 1, "R1 strobe", 16'(cmdCnt - c0), 16'd1);
      chk(lastCode == b, "R1 code", {8'd0, lastCode}, {8'd0, b});
    end else begin
      chk(cmdCnt == c0, valid ? "R10 no cmd" : "R2 no cmd", 16'(cmdCnt - c0), 16'd0);
    end
    chk(progCnt == p0 + int'(expProg), "R10 strobe", 16'(progCnt - p0), 16'(expProg));
    if (expProg) chk(lastProg == b, "R10 data", {8'd0, lastProg}, {8'd0, b});
    chk(diagActive == expDiag, "R7 mode", {15'd0, diagActive}, {15'd0, expDiag});
    chk(altMode == alt, "R8 mode", {15'd0, altMode}, {15'd0, alt});
    chk(misoOe == 1'b0, "R9 idle", {15'd0, misoOe}, 16'd0);
  endtask

  task automatic inject(input logic [7:0] v);
    diagResult = v; diagValid = 1'b1;
    waitClk(1);
    diagValid = 1'b0;
    waitClk(2);
    if (expDiag) expResp = expResp | v;
  endtask

  initial begin
    void'($urandom(32'd4242));
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    // reset state
    chk(misoOe == 1'b0, "R9 reset", {15'd0, misoOe}, 16'd0);
    chk(diagActive == 1'b0, "R6 reset", {15'd0, diagActive}, 16'd0);
    chk(altMode == 1'b0, "R8 reset", {15'd0, altMode}, 16'd0);

    doFrame(8'h00, 8, 1'b0);            // R3 reset response 0x00
    doFrame(8'h96, 8, 1'b0);            // R4 echo
    doFrame(8'h3C, 8, 1'b1);            // R4 reply; R8 idle-high
    doFrame(8'hC8, 8, 1'b0);            // R5 strap 0
    strapTwoCh = 1'b1;
    doFrame(8'hC8, 8, 1'b1);
    doFrame(8'h5A, 7, 1'b0);            // R2 short frame
    doFrame(8'h5A, 9, 1'b1);            // R2 long frame
    doFrame(8'hC2, 8, 1'b0);            // R6 diagnostic
    inject(8'h11);
    inject(8'h80);
    doFrame(8'h00, 8, 1'b0);            // R6 result; R7 cleared
    inject(8'hFF);                      // R6 ignored when idle
    doFrame(8'hD3, 8, 1'b1);
    doFrame(8'hD0, 8, 1'b0);            // R7 back-to-back diag clears
    doFrame(8'hA5, 8, 1'b0);            // R10 arm
    doFrame(8'h0F, 8, 1'b1);            // R10 data accepted
    doFrame(8'hA5, 8, 1'b0);
    driverActive = 1'b1;
    doFrame(8'h33, 8, 1'b0);            // R10 blocked by driver
    driverActive = 1'b0;
    doFrame(8'hA5, 8, 1'b0);
    doFrame(8'h44, 7, 1'b0);            // R10 discarded frame cancels arm
    doFrame(8'h44, 8, 1'b0);

    for (int k = 0; k < 70; k++) begin
      logic [7:0] b;
      int n;
      bit alt;
      case ($urandom % 8)
        0: b = 8'h96;
        1: b = 8'hC8;
        2: b = 8'hA5;
        3: b = 8'hC1;
        4: b = 8'hD0 | 8'($urandom % 4);
        5: b = 8'h00;
        default: b = 8'($urandom);
      endcase
      n = (($urandom % 10) == 0) ? ((($urandom % 2) == 0) ? 7 : 9) : 8;
      alt = 1'($urandom % 2);
      driverActive = (($urandom % 4) == 0);
      strapTwoCh = 1'($urandom % 2);
      if (($urandom % 3) == 0) inject(8'($urandom));
      doFrame(b, n, alt);
    end

    summary();
    $finish;
  end
endmodule